// File: doc/BRIEF.md
# Scanner sensor timing generator

This block drives the periodic control lines of a line-scan image sensor from one fast scaler clock. Every dot (pixel) period is cut into a fixed number of scaler-clock slots. Programmable slot positions place the rising and falling edges of a dot-rate clock inside each dot period. They also place the edges of a line start pulse. That pulse can be delayed, and stretched, by whole pixel periods inside each scan line.

While the start pulse is being issued, a quiet window of a programmable number of pixels begins. During that window each selected auxiliary control line holds the level it already had, so the only line that moves is the start pulse. Auxiliary lines that are not selected follow their request inputs.

All configuration inputs pass through a copy that is loaded only at the boundary between lines, so every line is produced from one consistent setting.

Top module: `sensor_timing_gen`

## Requirements
- R1: A slot counter steps once per clock through 0 to DOT_SLOTS-1. A pixel counter steps when the slot counter wraps and restarts after pixel LINE_PIX-1, which begins a new line. After reset is released, the first clock edge handles slot 0 of pixel 0.
- R2: When the dot-clock rise position is below its fall position, the dot clock is 1 for the slots from the rise position up to one less than the fall position, and 0 otherwise. Each output reflects the slot handled at the previous clock edge, which is one clock of latency.
- R3: When the dot-clock fall position is below its rise position, the dot clock is 1 for slots at or above the rise position and for slots below the fall position, so it stays high across the dot-period boundary.
- R4: When the dot-clock rise and fall positions are equal, the dot clock stays 0.
- R5: The start pulse is set by a delay D and a length L. It is 1 from slot start-rise of pixel D up to, but not including, slot start-fall of pixel D+L+1. It has the same one-clock latency as the dot clock.
- R6: Let the quiet length be Q, greater than zero. During pixels D to D+Q-1 of a line, each auxiliary output whose freeze-enable bit is 1 keeps its previous value. Bit i of the enable applies to aux bit i.
- R7: Outside the quiet window, when Q is 0, or when its enable bit is 0, an auxiliary output equals its request input as seen one clock earlier.
- R8: Configuration inputs are captured at the clock edge that ends the last slot of the last pixel of a line, and they govern the whole next line. A change made in the middle of a line has no effect until then.
- R9: Reset is asynchronous and active low. It clears every output, and it clears the captured configuration to all zeros, which the first line then uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | scaler clock |
| rst_n | input | 1 | asynchronous reset, active low |
| dclk_rise_i | input | 4 | dot-clock rising slot |
| dclk_fall_i | input | 4 | dot-clock falling slot |
| strt_rise_i | input | 4 | start pulse rising slot |
| strt_fall_i | input | 4 | start pulse falling slot |
| strt_delay_i | input | 4 | start pulse delay in pixels |
| strt_len_i | input | 4 | start pulse length minus one, in pixels |
| quiet_len_i | input | 5 | quiet window length in pixels |
| freeze_en_i | input | 3 | per-auxiliary-line freeze select |
| aux_req_i | input | 3 | requested auxiliary levels |
| dot_clk_o | output | 1 | dot-rate clock |
| line_start_o | output | 1 | line start pulse |
| aux_o | output | 3 | auxiliary control outputs |

## Verification
Every output is registered. Each value seen after clock edge k belongs to the slot and pixel handled at edge k, and the auxiliary lines use the request present at that edge. The bench therefore computes the expectation for edge k at the following falling edge and compares it a moment later. The configuration is copied into the bench model only after the edge that closes a line has been evaluated. A mid-line write is thus expected to change nothing until slot 0 of the next line is handled.

// File: rtl/sensor_tsg_pkg.sv
package sensor_tsg_pkg;
    localparam int POS_W = 4;
    localparam int OFS_W = 4;
    localparam int LEN_W = 4;
    localparam int QT_W  = 5;
    localparam int AUX_N = 3;

    typedef struct packed {
        logic [POS_W-1:0] dclk_rise;
        logic [POS_W-1:0] dclk_fall;
        logic [POS_W-1:0] sp_rise;
        logic [POS_W-1:0] sp_fall;
        logic [OFS_W-1:0] sp_delay;
        logic [LEN_W-1:0] sp_len;
        logic [QT_W-1:0]  quiet_len;
        logic [AUX_N-1:0] freeze_en;
    } tsg_cfg_t;
endpackage

// File: rtl/sensor_tsg_count.sv
module sensor_tsg_count #(
    parameter int DOT_SLOTS = 16,
    parameter int LINE_PIX  = 34,
    localparam int SLOT_W = $clog2(DOT_SLOTS),
    localparam int PIX_W  = $clog2(LINE_PIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output logic [PIX_W-1:0]  pix_o,
    output logic              line_end_o
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [PIX_W-1:0]  pix;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic slot_last, pix_last;

    always_comb begin
        cnt_d     = cnt_q;
        slot_last = (cnt_q.slot == SLOT_W'(DOT_SLOTS - 1));
        pix_last  = (cnt_q.pix == PIX_W'(LINE_PIX - 1));
        if (slot_last) begin
            cnt_d.slot = '0;
            cnt_d.pix  = pix_last ? '0 : cnt_q.pix + PIX_W'(1);
        end else begin
            cnt_d.slot = cnt_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign slot_o     = cnt_q.slot;
    assign pix_o      = cnt_q.pix;
    assign line_end_o = slot_last && pix_last;

    assert_pix_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q.pix) < LINE_PIX);

    assert_pix_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_last |=> cnt_q.pix != $past(cnt_q.pix));
endmodule

// File: rtl/sensor_tsg_shadow.sv
module sensor_tsg_shadow
    import sensor_tsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  tsg_cfg_t cfg_i,
    output tsg_cfg_t cfg_o
);
    typedef struct packed {
        tsg_cfg_t cfg;
    } shd_t;

    shd_t shd_d, shd_q;

    always_comb begin
        shd_d = shd_q;
        if (load_i) shd_d.cfg = cfg_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shd_q <= '0;
        else        shd_q <= shd_d;
    end

    assign cfg_o = shd_q.cfg;
endmodule

// File: rtl/sensor_tsg_wave.sv
module sensor_tsg_wave
    import sensor_tsg_pkg::*;
#(
    parameter int DOT_SLOTS = 16,
    parameter int LINE_PIX  = 34,
    localparam int SLOT_W = $clog2(DOT_SLOTS),
    localparam int PIX_W  = $clog2(LINE_PIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [PIX_W-1:0]  pix_i,
    input  tsg_cfg_t          cfg_i,
    input  logic [AUX_N-1:0]  aux_req_i,
    output logic              dot_clk_o,
    output logic              start_o,
    output logic [AUX_N-1:0]  aux_o
);
    localparam int CW  = (SLOT_W > POS_W) ? SLOT_W : POS_W;
    localparam int PWB = (PIX_W > QT_W + 1) ? PIX_W : QT_W + 1;
    localparam int PW  = PWB + 1;

    typedef struct packed {
        logic             dot;
        logic             start;
        logic [AUX_N-1:0] aux;
    } wav_t;

    wav_t wav_d, wav_q;
    logic [CW-1:0] s;
    logic [PW-1:0] p, dly, endp, qend;
    logic          started, not_ended, quiet;

    function automatic logic in_span(logic [CW-1:0] at, logic [CW-1:0] r, logic [CW-1:0] f);
        if (r == f)     return 1'b0;
        else if (r < f) return (at >= r) && (at < f);
        else            return (at >= r) || (at < f);
    endfunction

    always_comb begin
        wav_d     = wav_q;
        s         = CW'(slot_i);
        p         = PW'(pix_i);
        dly       = PW'(cfg_i.sp_delay);
        endp      = dly + PW'(cfg_i.sp_len) + PW'(1);
        qend      = dly + PW'(cfg_i.quiet_len);
        started   = (p > dly) || ((p == dly) && (s >= CW'(cfg_i.sp_rise)));
        not_ended = (p < endp) || ((p == endp) && (s < CW'(cfg_i.sp_fall)));
        quiet     = (cfg_i.quiet_len != '0) && (p >= dly) && (p < qend);

        wav_d.dot   = in_span(s, CW'(cfg_i.dclk_rise), CW'(cfg_i.dclk_fall));
        wav_d.start = started && not_ended;
        for (int i = 0; i < AUX_N; i++) begin
            wav_d.aux[i] = (quiet && cfg_i.freeze_en[i]) ? wav_q.aux[i] : aux_req_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wav_q <= '0;
        else        wav_q <= wav_d;
    end

    assign dot_clk_o = wav_q.dot;
    assign start_o   = wav_q.start;
    assign aux_o     = wav_q.aux;
endmodule

// File: rtl/sensor_timing_gen.sv
module sensor_timing_gen
    import sensor_tsg_pkg::*;
#(
    parameter int DOT_SLOTS = 16,
    parameter int LINE_PIX  = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] dclk_rise_i,
    input  logic [POS_W-1:0] dclk_fall_i,
    input  logic [POS_W-1:0] strt_rise_i,
    input  logic [POS_W-1:0] strt_fall_i,
    input  logic [OFS_W-1:0] strt_delay_i,
    input  logic [LEN_W-1:0] strt_len_i,
    input  logic [QT_W-1:0]  quiet_len_i,
    input  logic [AUX_N-1:0] freeze_en_i,
    input  logic [AUX_N-1:0] aux_req_i,
    output logic             dot_clk_o,
    output logic             line_start_o,
    output logic [AUX_N-1:0] aux_o
);
    localparam int SLOT_W = $clog2(DOT_SLOTS);
    localparam int PIX_W  = $clog2(LINE_PIX);

    tsg_cfg_t          cfg_in, cfg_act;
    logic [SLOT_W-1:0] slot;
    logic [PIX_W-1:0]  pix;
    logic              line_end;

    always_comb begin
        cfg_in.dclk_rise = dclk_rise_i;
        cfg_in.dclk_fall = dclk_fall_i;
        cfg_in.sp_rise   = strt_rise_i;
        cfg_in.sp_fall   = strt_fall_i;
        cfg_in.sp_delay  = strt_delay_i;
        cfg_in.sp_len    = strt_len_i;
        cfg_in.quiet_len = quiet_len_i;
        cfg_in.freeze_en = freeze_en_i;
    end

    sensor_tsg_count #(.DOT_SLOTS(DOT_SLOTS), .LINE_PIX(LINE_PIX)) u_count (
        .clk(clk), .rst_n(rst_n), .slot_o(slot), .pix_o(pix), .line_end_o(line_end)
    );

    sensor_tsg_shadow u_shadow (
        .clk(clk), .rst_n(rst_n), .load_i(line_end), .cfg_i(cfg_in), .cfg_o(cfg_act)
    );

    sensor_tsg_wave #(.DOT_SLOTS(DOT_SLOTS), .LINE_PIX(LINE_PIX)) u_wave (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .pix_i(pix), .cfg_i(cfg_act),
        .aux_req_i(aux_req_i), .dot_clk_o(dot_clk_o), .start_o(line_start_o), .aux_o(aux_o)
    );

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(cfg_act));

    assert_dclk_flat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_act.dclk_rise == cfg_act.dclk_fall) |=> !dot_clk_o);

    assert_start_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_start_o) |-> int'($past(pix)) == int'($past(cfg_act.sp_delay)));

    assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_act.quiet_len == '0) |=> aux_o == $past(aux_req_i));

    for (genvar g = 0; g < AUX_N; g++) begin : g_frz
        assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_act.freeze_en[g] && cfg_act.quiet_len != '0 &&
             int'(pix) == int'(cfg_act.sp_delay)) |=> $stable(aux_o[g]));
    end
endmodule

// File: tb/sim_sensor_timing_gen.sv
module sim_sensor_timing_gen;
    localparam int D  = 16;
    localparam int P  = 34;
    localparam int LN = D * P;
    localparam int NLINES = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] dclk_rise, dclk_fall, strt_rise, strt_fall, strt_delay, strt_len;
    logic [4:0] quiet_len;
    logic [2:0] freeze_en, aux_req;
    logic       dot_clk, line_start;
    logic [2:0] aux;

    int  vectors = 0;
    int  miscomp = 0;
    bit  done = 1'b0;

    typedef struct {
        logic       dot;
        logic       st;
        logic [2:0] ax;
        int         td;
        int         ts;
        int         ta;
        int         k;
    } exp_t;
    exp_t sb[$];

    int m_dr, m_df, m_sr, m_sf, m_dl, m_ln, m_q, m_en;
    logic [2:0] m_aux = 3'b000;

    always #5 clk = ~clk;

    sensor_timing_gen #(.DOT_SLOTS(D), .LINE_PIX(P)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dclk_rise_i(dclk_rise), .dclk_fall_i(dclk_fall),
        .strt_rise_i(strt_rise), .strt_fall_i(strt_fall),
        .strt_delay_i(strt_delay), .strt_len_i(strt_len),
        .quiet_len_i(quiet_len), .freeze_en_i(freeze_en), .aux_req_i(aux_req),
        .dot_clk_o(dot_clk), .line_start_o(line_start), .aux_o(aux)
    );

    task automatic chk(string what, int tag, int k, logic [2:0] act, logic [2:0] exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL R%0d %s edge %0d: actual %b expected %b", tag, what, k, act, exp);
        end
    endtask

    function automatic logic [2:0] pat(int k);
        return 3'((k / 3) ^ (k / 11));
    endfunction

    task automatic set_cfg(int dr, int df, int sr, int sf, int dl, int ln, int q, int en);
        dclk_rise = 4'(dr); dclk_fall = 4'(df); strt_rise = 4'(sr); strt_fall = 4'(sf);
        strt_delay = 4'(dl); strt_len = 4'(ln); quiet_len = 5'(q); freeze_en = 3'(en);
    endtask

    function automatic bit cfg_pending();
        return (int'(dclk_rise) != m_dr) || (int'(dclk_fall) != m_df) ||
               (int'(strt_rise) != m_sr) || (int'(strt_fall) != m_sf) ||
               (int'(strt_delay) != m_dl) || (int'(strt_len) != m_ln) ||
               (int'(quiet_len) != m_q) || (int'(freeze_en) != m_en);
    endfunction

    // Driver: computes the expected outputs for clock edge k and queues them.
    task automatic push_expect(int k);
        exp_t e;
        int slot, pix, pos;
        bit quiet, frz;
        slot = k % D;
        pix  = (k / D) % P;
        pos  = pix * D + slot;
        e.k  = k;
        // R2 ordered span, R3 wrapping span, R4 equal positions give a flat low
        if (m_dr == m_df)     e.dot = 1'b0;
        else if (m_dr < m_df) e.dot = (slot >= m_dr) && (slot < m_df);
        else                  e.dot = (slot >= m_dr) || (slot < m_df);
        e.td = (slot == D - 1) ? 1 : (m_dr == m_df) ? 4 : (m_dr < m_df) ? 2 : 3;
        // R5 start pulse window in linear slot time
        e.st = (pos >= m_dl * D + m_sr) && (pos < (m_dl + m_ln + 1) * D + m_sf);
        e.ts = cfg_pending() ? 8 : 5;
        // R6 quiet window freezes, R7 otherwise follow the request
        quiet = (m_q != 0) && (pix >= m_dl) && (pix < m_dl + m_q);
        frz = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (quiet && m_en[i]) frz = 1'b1;
            else m_aux[i] = aux_req[i];
        end
        e.ax = m_aux;
        e.ta = frz ? 6 : 7;
        if (k < LN) begin
            e.td = 9; e.ts = 9; e.ta = 9;   // R9 zero configuration during the first line
        end
        sb.push_back(e);
    endtask

    // Monitor: compares queued expectations just after the falling edge.
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk("dot_clk", e.td, e.k, {2'b00, dot_clk}, {2'b00, e.dot});
            chk("line_start", e.ts, e.k, {2'b00, line_start}, {2'b00, e.st});
            chk("aux", e.ta, e.k, aux, e.ax);
        end
    end

    initial begin
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
        aux_req = 3'b000;
        m_dr = 0; m_df = 0; m_sr = 0; m_sf = 0; m_dl = 0; m_ln = 0; m_q = 0; m_en = 0;
        set_cfg(5, 9, 1, 2, 3, 4, 5, 7);   // R9 driven inputs must not matter in reset
        aux_req = 3'b111;
        repeat (3) @(negedge clk);
        #1;
        chk("reset dot_clk", 9, -1, {2'b00, dot_clk}, 3'b000);
        chk("reset line_start", 9, -1, {2'b00, line_start}, 3'b000);
        chk("reset aux", 9, -1, aux, 3'b000);
        @(negedge clk);
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
        aux_req = pat(0);
        rst_n = 1'b1;
        for (int k = 0; k < NLINES * LN; k++) begin
            @(negedge clk);
            push_expect(k);
            if (k % LN == LN - 1) begin   // R8 capture at the line boundary
                m_dr = int'(dclk_rise); m_df = int'(dclk_fall);
                m_sr = int'(strt_rise); m_sf = int'(strt_fall);
                m_dl = int'(strt_delay); m_ln = int'(strt_len);
                m_q = int'(quiet_len); m_en = int'(freeze_en);
            end
            aux_req = pat(k + 1);
            if (k % LN == 200) begin
                case (k / LN)
                    0: set_cfg(2, 9, 3, 5, 2, 1, 4, 3'b101);
                    1: set_cfg(12, 4, 10, 2, 0, 3, 0, 3'b111);
                    2: set_cfg(7, 7, 0, 15, 15, 15, 31, 3'b010);
                    3: set_cfg(0, 15, 15, 0, 5, 0, 1, 3'b111);
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        #2;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscomp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end
endmodule